// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width modulated outputs from one input clock. Each channel divides the clock by a 6-bit prescale value plus one to form a tick. It counts ticks up to a 16-bit period count, and it holds its output active while the tick count is below a 16-bit duty count. A single control word holds, for every channel, an enable bit, a polarity bit and a drive-style bit.

Software programs the block through a simple 32-bit register bus with separate write and read strobes. The usual sequence is to disable a channel, load its counts, and then enable it again. Every channel drives a pin value together with an output-enable. A channel can therefore act as a push-pull driver, or as an open-drain style driver that only ever pulls low. Any count written while a channel runs is picked up at the next period boundary, so a period in progress is never cut short.

Top module: `pwm4_ctrl`

## Requirements
- R1: Register layout, given as byte offsets on `bus_addr`. The control word is at 0x00. Enable for channel c is bit c, polarity is bit 8+c and drive style is bit 15+c, for c = 0..3. The period count of channel c is at 0x04+8c and its duty count is at 0x08+8c, each in bits [15:0]. The prescale word is at 0x24 and holds four 6-bit fields; channel c sits at bit (3-c)*6, so channel 3 is bits [5:0] and channel 0 is bits [23:18]. A write stores the data. A read returns the stored value one cycle after `bus_rd`, and `bus_rdata` holds that value until the next read. Unused bits read 0, and unmapped offsets read 0.
- R2: Reset clears every register and `bus_rdata` to zero. With all control bits at zero, every `pwm_o` is 1 and every `pwm_oe_o` is 1.
- R3: While a channel is enabled with period count P ≥ 2, duty count D and prescale S, its waveform repeats every (S+1)*P clocks. The first (S+1)*D clocks of each period are active.
- R4: A polarity bit of 1 makes the active level high. A polarity bit of 0 inverts the waveform, so the active level is low.
- R5: While a channel is disabled, its prescaler and tick counter stay at zero and its output sits at the inactive level. In the cycle after the write edge that sets the enable bit, the output shows the first clock of a fresh period.
- R6: A duty count of 0 gives a constant inactive output. A duty count equal to or greater than the period count gives a constant active output.
- R7: A period, duty or prescale value written while a channel runs takes effect at the next period boundary. Polarity and drive style take effect at once.
- R8: Drive style 0 (push-pull) sets `pwm_oe_o` to 1 and puts the logic level on `pwm_o`. Drive style 1 (open-drain) holds `pwm_o` at 0 and sets `pwm_oe_o` to 1 only while the level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock for the counters and registers |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pwm_o | output | 4 | Pin value per channel |
| pwm_oe_o | output | 4 | Output-enable per channel |

## Verification
The bench checks the reversed packing of the prescale fields by running channel 2 with a prescale of 2. A design that mapped the fields in channel order would leave that channel unscaled, and its period would come out three times too short. It changes a period count in the middle of a running period and expects the old period to complete before the new one begins; a design that loaded counts at once would cut the period short. It also stops a channel part way through a period and starts it again, expecting the restart at count zero, and it checks both duty extremes and the open-drain style. A design that resumed at the old count, or that glitched at those extremes, would break the expected waveform in the cycles that follow.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
    localparam int NCH       = 4;
    localparam int CNT_W     = 16;
    localparam int PRE_W     = 6;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 6;
    localparam int POL_LSB   = 8;
    localparam int DRV_LSB   = 15;
    localparam int CTRL_IDX  = 0;
    localparam int PRE_IDX   = 9;

    // configuration seen by one channel
    typedef struct packed {
        logic             en;
        logic             pol;
        logic             od;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
    } chan_cfg_t;

    // register file state
    typedef struct packed {
        logic [NCH-1:0]             en;
        logic [NCH-1:0]             pol;
        logic [NCH-1:0]             od;
        logic [NCH-1:0][PRE_W-1:0]  pre;
        logic [NCH-1:0][CNT_W-1:0]  per;
        logic [NCH-1:0][CNT_W-1:0]  duty;
        logic [DATA_W-1:0]          rdata;
    } regs_t;

    // channel counter state
    typedef struct packed {
        logic [PRE_W-1:0] pre_cnt;
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] act_pre;
        logic [CNT_W-1:0] act_per;
        logic [CNT_W-1:0] act_duty;
    } chan_st_t;
endpackage

// File: rtl/pwm4_regfile.sv
module pwm4_regfile
    import pwm4_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic                   rd,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    output chan_cfg_t [NCH-1:0]    cfg_o
);
    regs_t             rg_d, rg_q;
    int                widx;
    logic [DATA_W-1:0] rword;

    always_comb begin
        widx  = int'(addr >> 2);
        rg_d  = rg_q;
        rword = '0;

        // write path
        if (wr) begin
            for (int c = 0; c < NCH; c++) begin
                if (widx == CTRL_IDX) begin
                    rg_d.en[c]  = wdata[c];
                    rg_d.pol[c] = wdata[POL_LSB + c];
                    rg_d.od[c]  = wdata[DRV_LSB + c];
                end
                if (widx == 1 + 2 * c) rg_d.per[c]  = wdata[CNT_W-1:0];
                if (widx == 2 + 2 * c) rg_d.duty[c] = wdata[CNT_W-1:0];
                if (widx == PRE_IDX)
                    rg_d.pre[c] = wdata[(NCH-1-c)*PRE_W +: PRE_W];
            end
        end

        // read path
        for (int c = 0; c < NCH; c++) begin
            if (widx == CTRL_IDX) begin
                rword[c]           = rg_q.en[c];
                rword[POL_LSB + c] = rg_q.pol[c];
                rword[DRV_LSB + c] = rg_q.od[c];
            end
            if (widx == 1 + 2 * c) rword[CNT_W-1:0] = rg_q.per[c];
            if (widx == 2 + 2 * c) rword[CNT_W-1:0] = rg_q.duty[c];
            if (widx == PRE_IDX)
                rword[(NCH-1-c)*PRE_W +: PRE_W] = rg_q.pre[c];
        end
        if (rd) rg_d.rdata = rword;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign rdata = rg_q.rdata;

    for (genvar g = 0; g < NCH; g++) begin : g_cfg
        assign cfg_o[g].en   = rg_q.en[g];
        assign cfg_o[g].pol  = rg_q.pol[g];
        assign cfg_o[g].od   = rg_q.od[g];
        assign cfg_o[g].pre  = rg_q.pre[g];
        assign cfg_o[g].per  = rg_q.per[g];
        assign cfg_o[g].duty = rg_q.duty[g];
    end
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
    import pwm4_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg_i,
    output logic      pin_o,
    output logic      oe_o
);
    chan_st_t       st_d, st_q;
    logic [CNT_W:0] cnt_inc;
    logic           active;
    logic           level;

    always_comb begin
        st_d    = st_q;
        cnt_inc = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};

        if (!cfg_i.en) begin
            // idle: counters parked, counts follow the registers
            st_d.pre_cnt  = '0;
            st_d.cnt      = '0;
            st_d.act_pre  = cfg_i.pre;
            st_d.act_per  = cfg_i.per;
            st_d.act_duty = cfg_i.duty;
        end else if (st_q.pre_cnt == st_q.act_pre) begin
            st_d.pre_cnt = '0;
            if (cnt_inc >= {1'b0, st_q.act_per}) begin
                // period boundary: pick up any new counts
                st_d.cnt      = '0;
                st_d.act_pre  = cfg_i.pre;
                st_d.act_per  = cfg_i.per;
                st_d.act_duty = cfg_i.duty;
            end else begin
                st_d.cnt = cnt_inc[CNT_W-1:0];
            end
        end else begin
            st_d.pre_cnt = st_q.pre_cnt + 1'b1;
        end

        active = cfg_i.en && (st_q.cnt < st_q.act_duty);
        level  = cfg_i.pol ? active : !active;
        pin_o  = cfg_i.od ? 1'b0 : level;
        oe_o   = cfg_i.od ? !level : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl
    import pwm4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_o,
    output logic [NCH-1:0]    pwm_oe_o
);
    chan_cfg_t [NCH-1:0] cfg;

    pwm4_regfile regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg_o (cfg)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm4_chan chan_i (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg_i (cfg[g]),
            .pin_o (pwm_o[g]),
            .oe_o  (pwm_oe_o[g])
        );
    end
endmodule

// File: rtl/pwm4_chk.sv
module pwm4_chk
    import pwm4_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input chan_cfg_t        cfg_i,
    input logic             pin_o,
    input logic             oe_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic [PRE_W-1:0] pre_q,
    input logic [CNT_W-1:0] act_per_q,
    input logic [CNT_W-1:0] act_duty_q
);
    // R5: disabled channel parks its counters
    a_r5_idle_counters: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |=> (cnt_q == '0 && pre_q == '0));

    // R5: disabled channel sits at the inactive level
    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.en && !cfg_i.od) |-> (pin_o == !cfg_i.pol && oe_o));

    // R8: push-pull always drives
    a_r8_push_pull_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.od |-> oe_o);

    // R8: open-drain never drives high
    a_r8_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i.od |-> !pin_o);

    // R7: counts in use stay fixed inside a period
    a_r7_counts_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.en && $past(cfg_i.en) && !(cnt_q == '0 && pre_q == '0))
            |-> ($stable(act_per_q) && $stable(act_duty_q)));

    // R3: tick counter stays inside the period
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.en && act_per_q >= 2) |-> (cnt_q < act_per_q));

    // R6: zero duty never shows the active level
    a_r6_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.en && act_duty_q == '0 && !cfg_i.od) |-> (pin_o == !cfg_i.pol));
endmodule

bind pwm4_chan pwm4_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_i      (cfg_i),
    .pin_o      (pin_o),
    .oe_o       (oe_o),
    .cnt_q      (st_q.cnt),
    .pre_q      (st_q.pre_cnt),
    .act_per_q  (st_q.act_per),
    .act_duty_q (st_q.act_duty)
);

// File: tb/pwm4_ctrl_tb_top.sv
module pwm4_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_o;
    logic [3:0]  pwm_oe_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          when;
        int          kind;   // 0 rdata, 1 pin, 2 output-enable
        int          idx;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    pwm4_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o)
    );

    // monitor: compare every item due this cycle
    always @(negedge clk) begin
        for (int k = sb.size() - 1; k >= 0; k--) begin
            if (sb[k].when == cyc) begin
                logic [31:0] act;
                case (sb[k].kind)
                    0:       act = bus_rdata;
                    1:       act = {31'b0, pwm_o[sb[k].idx]};
                    default: act = {31'b0, pwm_oe_o[sb[k].idx]};
                endcase
                n_chk++;
                if (act !== sb[k].exp) begin
                    n_fail++;
                    $display("FAIL %s kind%0d ch%0d cyc%0d: actual %h expected %h",
                             sb[k].req, sb[k].kind, sb[k].idx, cyc, act, sb[k].exp);
                end
                sb.delete(k);
            end
        end
    end

    task automatic push(int when, int kind, int idx, logic [31:0] exp, string req);
        item_t it;
        it.when = when; it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [5:0] a, logic [31:0] exp, string req);
        push(cyc + 1, 0, 0, exp, req);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // expected pin and enable for samples j0..j1-1 after enable (sample j at base+j)
    task automatic exp_wave(int ch, int per, int pre, int duty, bit pol, bit od,
                            int base, int j0, int j1, int jofs, string req);
        for (int j = j0; j < j1; j++) begin
            int  ph;
            bit  act, lvl;
            ph  = (j - jofs) % (per * (pre + 1));
            act = (ph / (pre + 1)) < duty;
            lvl = pol ? act : !act;
            push(base + j, 1, ch, {31'b0, od ? 1'b0 : lvl}, req);
            push(base + j, 2, ch, {31'b0, od ? !lvl : 1'b1}, req);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int c;
        idle(3);
        rst_n = 1'b1;

        // R2: reset state
        push(cyc + 1, 1, 0, 32'd1, "R2");
        push(cyc + 1, 2, 3, 32'd1, "R2");
        rd_chk(6'h00, 32'h0, "R2");
        rd_chk(6'h04, 32'h0, "R2");
        rd_chk(6'h24, 32'h0, "R2");

        // R1: readback masking and layout
        wr(6'h00, 32'hFFFF_FFFF);
        rd_chk(6'h00, 32'h0007_8F0F, "R1");
        wr(6'h00, 32'h0);
        wr(6'h04, 32'hFFFF_FFFF);
        rd_chk(6'h04, 32'h0000_FFFF, "R1");
        wr(6'h24, 32'hFFFF_FFFF);
        rd_chk(6'h24, 32'h00FF_FFFF, "R1");
        wr(6'h20, 32'hABCD_1234);
        rd_chk(6'h20, 32'h0000_1234, "R1");
        rd_chk(6'h28, 32'h0, "R1");
        rd_chk(6'h3C, 32'h0, "R1");
        wr(6'h24, 32'h0000_0080);         // channel 2 prescale = 2
        rd_chk(6'h24, 32'h0000_0080, "R1");

        // R3: channel 0, period 5, duty 2, no prescale
        wr(6'h04, 32'd5);
        wr(6'h08, 32'd2);
        c = cyc;
        exp_wave(0, 5, 0, 2, 1, 0, c + 1, 0, 15, 0, "R3");
        wr(6'h00, 32'h0000_0101);
        idle(16);
        wr(6'h00, 32'h0);

        // R3: channel 2 prescaled by 3 (reversed field packing)
        wr(6'h14, 32'd3);
        wr(6'h18, 32'd1);
        c = cyc;
        exp_wave(2, 3, 2, 1, 1, 0, c + 1, 0, 18, 0, "R3");
        wr(6'h00, 32'h0000_0404);
        idle(19);
        wr(6'h00, 32'h0);

        // R4: channel 1 inverted
        wr(6'h0C, 32'd4);
        wr(6'h10, 32'd1);
        c = cyc;
        exp_wave(1, 4, 0, 1, 0, 0, c + 1, 0, 8, 0, "R4");
        wr(6'h00, 32'h0000_0002);
        idle(9);
        wr(6'h00, 32'h0);

        // R6: duty zero, then duty above period
        wr(6'h04, 32'd3);
        wr(6'h08, 32'd0);
        c = cyc;
        exp_wave(0, 3, 0, 0, 1, 0, c + 1, 0, 6, 0, "R6");
        wr(6'h00, 32'h0000_0101);
        idle(7);
        wr(6'h00, 32'h0);
        wr(6'h08, 32'd7);
        c = cyc;
        exp_wave(0, 3, 0, 3, 1, 0, c + 1, 0, 6, 0, "R6");
        wr(6'h00, 32'h0000_0101);
        idle(7);
        wr(6'h00, 32'h0);

        // R5: stop mid-period, idle level, restart at zero
        wr(6'h04, 32'd4);
        wr(6'h08, 32'd2);
        c = cyc;
        exp_wave(0, 4, 0, 2, 1, 0, c + 1, 0, 6, 0, "R5");
        wr(6'h00, 32'h0000_0101);
        idle(6);
        for (int k = 1; k <= 3; k++) begin
            push(cyc + k, 1, 0, 32'd0, "R5");
            push(cyc + k, 2, 0, 32'd1, "R5");
        end
        wr(6'h00, 32'h0000_0100);
        idle(2);
        c = cyc;
        exp_wave(0, 4, 0, 2, 1, 0, c + 1, 0, 8, 0, "R5");
        wr(6'h00, 32'h0000_0101);
        idle(9);
        wr(6'h00, 32'h0);

        // R7: new period written mid-period waits for the boundary
        c = cyc;
        exp_wave(0, 4, 0, 2, 1, 0, c + 1, 0, 8, 0, "R7");
        exp_wave(0, 6, 0, 2, 1, 0, c + 1, 8, 20, 8, "R7");
        wr(6'h00, 32'h0000_0101);
        idle(5);
        wr(6'h04, 32'd6);
        idle(14);
        wr(6'h00, 32'h0);
        rd_chk(6'h04, 32'd6, "R1");

        // R8: channel 3 open-drain
        wr(6'h1C, 32'd4);
        wr(6'h20, 32'd1);
        c = cyc;
        exp_wave(3, 4, 0, 1, 1, 1, c + 1, 0, 8, 0, "R8");
        wr(6'h00, 32'h0004_0808);
        idle(9);
        wr(6'h00, 32'h0);
        idle(3);

        n_chk  += sb.size();
        n_fail += sb.size();
        if (sb.size() != 0)
            $display("FAIL scoreboard: actual %0d unchecked expected 0", sb.size());
        done = 1'b1;
        summary();
        $finish;
    end
endmodule